// File: doc/BRIEF.md
# Single-Channel Block Mover with Bus Request Handshake

This controller copies a block of words between one peripheral and memory, so that the processor does not have to move each word itself. Before a transfer the processor programs a start address, a word count, a direction and an ownership policy through a small register port. It may do so only while it owns the bus, which is while the bus grant is low. Writing the go bit arms the channel. From then on every word waits for the peripheral's request. The controller then raises a bus request, waits for the grant, performs one memory access, and pulses an acknowledge back to the peripheral. After the last word it releases the bus and raises a sticky interrupt.

There are two ownership policies. In cycle-steal mode the bus is handed back after every word and requested again for the next. In burst mode the request stays high from the first grant until the block is finished, including while the peripheral pauses between words.

The sequencer has six states. IDLE waits for a start. ARM waits for the peripheral request. GRANT holds the bus request until the grant arrives. ACCESS drives the memory strobe. RDATA is the extra cycle a memory read needs. HOLD keeps the bus in burst mode while the peripheral is not requesting. The transitions are as follows:
- IDLE goes to ARM on a start with a non-zero count. It stays in IDLE on a start with a zero count.
- ARM goes to GRANT when the peripheral requests.
- GRANT goes to ACCESS when the grant arrives.
- ACCESS goes to RDATA when reading.
- After a word (from ACCESS when writing, or from RDATA) the next state is chosen as follows:
  - IDLE if the count was one.
  - ARM in cycle-steal mode.
  - ACCESS in burst mode if the peripheral is still requesting.
  - HOLD in burst mode otherwise.
- HOLD goes to ACCESS when the peripheral requests and the grant is present.

Top module: `blk_dma_ctrl`

## Requirements
- R1: After reset the channel is idle, `bus_req` and `irq` are low, and all four registers read back as zero.
- R2: Register offsets on `cfg_addr`:
  - 0 holds the memory address.
  - 1 holds the word count.
  - 2 is control: bit0 is the direction, bit1 selects burst (1) or cycle-steal (0), and writing 1 to bit2 starts a transfer.
  - 3 is status: bit0 is the interrupt and bit1 is busy. Writing 1 to bit0 clears the interrupt.
  - Reads return the live register values, and `cfg_rdata` responds combinationally to `cfg_sel`.
- R3: While `bus_grant` is high, register writes have no effect and reads return zero.
- R4: While a transfer is busy, writes to address, count and control are ignored, including a new start.
- R5: `bus_req` rises only while `per_req` is high. `mem_rd` or `mem_wr` is asserted only while `bus_grant` is high.
- R6: Each moved word increments the address register by one and decrements the count by one. After a block of N words the address reads base+N and the count reads 0.
- R7: With direction 0, `mem_wr` and `per_ack` are high in the same single cycle. `per_wdata` is written to `mem_addr` in that cycle, and no word beyond the block is written.
- R8: With direction 1, `mem_rd` is high for one cycle. `per_ack` follows in the next cycle, with `per_rdata` carrying the memory data read for that word.
- R9: In cycle-steal mode `bus_req` goes low after every word, so a block of N words raises `bus_req` N times.
- R10: In burst mode `bus_req` rises once per block and stays high until the last word, including cycles in which `per_req` is low between words.
- R11: After the last word `bus_req` drops and `irq` is set. `irq` stays set until status bit0 is written with 1.
- R12: A start with a count of zero sets `irq` on the writing clock edge and never raises `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Register port select |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data |
| bus_req | output | 1 | Request for bus ownership |
| bus_grant | input | 1 | Bus ownership granted |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_rd` |
| per_req | input | 1 | Peripheral word request |
| per_ack | output | 1 | Peripheral word acknowledge |
| per_wdata | input | DW | Data from the peripheral |
| per_rdata | output | DW | Data to the peripheral |
| irq | output | 1 | Sticky block-complete interrupt |

## Verification
A sequencer that leaves a word-end state on the wrong branch shows at the ports at once. In cycle-steal mode it produces the wrong number of `bus_req` rises, and in burst mode HOLD cycles appear or go missing. A datapath off by one word shows as a wrong final address or count on the next register read, as an overrun word just past the block, or as read data one word out of step at `per_ack`. A lost or early completion shows within a cycle of the last acknowledge, as `irq` wrong or `bus_req` still high. Each combination of direction, policy, count (including zero) and pacing is swept, and every moved word is compared against an arithmetic pattern.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_GRANT,
        ST_ACCESS,
        ST_RDATA,
        ST_HOLD
    } dma_state_e;

    localparam logic [1:0] REG_ADDR  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;
    localparam logic [1:0] REG_STAT  = 2'd3;

    localparam int CTRL_DIR   = 0;
    localparam int CTRL_BURST = 1;
    localparam int CTRL_GO    = 2;
    localparam int STAT_IRQ   = 0;
    localparam int STAT_BUSY  = 1;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sel,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          bus_grant,
    input  logic          busy,
    input  logic          step,
    input  logic          done_set,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q,
    output logic          dir_q,
    output logic          burst_q,
    output logic          start_pulse,
    output logic          irq_q
);

    logic wr_ok;
    logic irq_clr;

    // The processor may write only while it owns the bus.
    assign wr_ok       = cfg_sel && cfg_wr && !bus_grant;
    assign start_pulse = wr_ok && (cfg_addr == REG_CTRL) && cfg_wdata[CTRL_GO] && !busy;
    assign irq_clr     = wr_ok && (cfg_addr == REG_STAT) && cfg_wdata[STAT_IRQ];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
            burst_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (step) begin
                addr_q <= addr_q + AW'(1);
                cnt_q  <= cnt_q - CW'(1);
            end else if (wr_ok && !busy) begin
                if (cfg_addr == REG_ADDR)  addr_q <= cfg_wdata;
                if (cfg_addr == REG_COUNT) cnt_q  <= cfg_wdata[CW-1:0];
                if (cfg_addr == REG_CTRL) begin
                    dir_q   <= cfg_wdata[CTRL_DIR];
                    burst_q <= cfg_wdata[CTRL_BURST];
                end
            end
            if (done_set)     irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel && !bus_grant) begin
            case (cfg_addr)
                REG_ADDR:  cfg_rdata = addr_q;
                REG_COUNT: cfg_rdata[CW-1:0] = cnt_q;
                REG_CTRL: begin
                    cfg_rdata[CTRL_DIR]   = dir_q;
                    cfg_rdata[CTRL_BURST] = burst_q;
                end
                default: begin
                    cfg_rdata[STAT_IRQ]  = irq_q;
                    cfg_rdata[STAT_BUSY] = busy;
                end
            endcase
        end
    end

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == $past(addr_q) + AW'(1)) && (cnt_q == $past(cnt_q) - CW'(1)));

    // R3
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_wr && bus_grant && !step) |=> $stable(addr_q) && $stable(cnt_q));

    // R11
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_pulse,
    input  logic [CW-1:0] cnt_q,
    input  logic          dir_q,
    input  logic          burst_q,
    input  logic          per_req,
    input  logic          bus_grant,
    output logic          bus_req,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          per_ack,
    output logic          step,
    output logic          done_set,
    output logic          busy
);

    dma_state_e st, nxt, after_word;
    logic last;
    logic word_end;
    logic zero_start;

    assign last       = (cnt_q == CW'(1));
    assign zero_start = (st == ST_IDLE) && start_pulse && (cnt_q == '0);

    always_comb begin
        if (last)          after_word = ST_IDLE;
        else if (!burst_q) after_word = ST_ARM;
        else if (per_req)  after_word = ST_ACCESS;
        else               after_word = ST_HOLD;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (start_pulse && (cnt_q != '0)) nxt = ST_ARM;
            ST_ARM:    if (per_req) nxt = ST_GRANT;
            ST_GRANT:  if (bus_grant) nxt = ST_ACCESS;
            ST_ACCESS: nxt = dir_q ? ST_RDATA : after_word;
            ST_RDATA:  nxt = after_word;
            ST_HOLD:   if (per_req && bus_grant) nxt = ST_ACCESS;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        bus_req  = (st == ST_GRANT) || (st == ST_ACCESS) || (st == ST_RDATA) || (st == ST_HOLD);
        mem_wr   = (st == ST_ACCESS) && !dir_q;
        mem_rd   = (st == ST_ACCESS) && dir_q;
        word_end = ((st == ST_ACCESS) && !dir_q) || (st == ST_RDATA);
        per_ack  = word_end;
        step     = word_end;
        done_set = (word_end && last) || zero_start;
        busy     = (st != ST_IDLE);
    end

    // R5
    strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> bus_grant);

    // R5
    req_after_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(per_req));

    // R8
    read_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (per_ack && !mem_rd));

    // R9
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_ack && !burst_q) |=> !bus_req);

    // R10
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && burst_q && !(per_ack && last)) |=> bus_req);

    // R11
    block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_ack && last) |=> (!bus_req && !busy));

    // R12
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_start |=> (!busy && !bus_req));

endmodule

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sel,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          per_req,
    output logic          per_ack,
    input  logic [DW-1:0] per_wdata,
    output logic [DW-1:0] per_rdata,
    output logic          irq
);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic dir_q, burst_q, start_pulse;
    logic step, done_set, busy;

    dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_sel    (cfg_sel),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .bus_grant  (bus_grant),
        .busy       (busy),
        .step       (step),
        .done_set   (done_set),
        .addr_q     (addr_q),
        .cnt_q      (cnt_q),
        .dir_q      (dir_q),
        .burst_q    (burst_q),
        .start_pulse(start_pulse),
        .irq_q      (irq)
    );

    dma_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pulse(start_pulse),
        .cnt_q      (cnt_q),
        .dir_q      (dir_q),
        .burst_q    (burst_q),
        .per_req    (per_req),
        .bus_grant  (bus_grant),
        .bus_req    (bus_req),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .per_ack    (per_ack),
        .step       (step),
        .done_set   (done_set),
        .busy       (busy)
    );

    assign mem_addr  = addr_q;
    assign mem_wdata = per_wdata;
    assign per_rdata = mem_rdata;

endmodule

// File: tb/blk_dma_ctrl_tb.sv
`timescale 1ns/1ps
module blk_dma_ctrl_tb;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sel = 1'b0, cfg_wr = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic bus_req, bus_grant, mem_rd, mem_wr, per_req, per_ack, irq;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, per_wdata, per_rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic force_gnt = 1'b0;
    logic per_en = 1'b0;
    logic gap_mode = 1'b0;
    logic cur_dir = 1'b0;
    int cur_run = 0;
    logic clr_mon = 1'b0;

    int ack_cnt, req_rises, req_falls, hold_cycles, viol;
    int gap_cnt;
    logic prev_req;
    logic [DW-1:0] mem [0:1023];
    logic [DW-1:0] rx [0:7];

    always #4 clk = ~clk;

    blk_dma_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_grant(bus_grant),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_ack(per_ack),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .irq(irq)
    );

    function automatic logic [DW-1:0] pat(input int run, input int idx);
        return DW'(16'h3C00 + run * 16 + idx);
    endfunction

    // Bus arbiter: grants one cycle after the request, drops one cycle after release.
    always @(posedge clk) begin
        if (!rst_n) bus_grant <= 1'b0;
        else        bus_grant <= bus_req | force_gnt;
    end

    // Memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    // Peripheral: drops its request with the acknowledge and pauses two cycles in gap mode.
    assign per_req   = per_en && (gap_cnt == 0) && !(gap_mode && per_ack);
    assign per_wdata = pat(cur_run, ack_cnt);

    always @(posedge clk) begin
        if (clr_mon || !rst_n) begin
            ack_cnt <= 0; req_rises <= 0; req_falls <= 0;
            hold_cycles <= 0; viol <= 0; gap_cnt <= 0; prev_req <= 1'b0;
        end else begin
            prev_req <= bus_req;
            if (bus_req && !prev_req) req_rises <= req_rises + 1;
            if (!bus_req && prev_req) req_falls <= req_falls + 1;
            if (bus_req && !per_req && !per_ack && !mem_rd) hold_cycles <= hold_cycles + 1;
            if ((mem_rd || mem_wr) && !bus_grant) viol <= viol + 1;
            if (per_ack) begin
                if (cur_dir) rx[ack_cnt[2:0]] <= per_rdata;
                ack_cnt <= ack_cnt + 1;
            end
            if (per_ack && gap_mode) gap_cnt <= 2;
            else if (gap_cnt != 0)   gap_cnt <= gap_cnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [AW-1:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b0; cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_sel = 1'b0;
    endtask

    task automatic clear_monitors();
        @(negedge clk);
        clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic run_block(input bit dir, input bit burst, input int cnt, input bit gap, input int run);
        logic [AW-1:0] base, rd;
        int exp_rises, exp_hold;
        base = AW'(16 + run * 12);
        for (int i = 0; i < 8; i++) begin
            mem[base + i] = dir ? pat(run, i) : '0;
        end
        cur_dir = dir; cur_run = run; gap_mode = gap;
        clear_monitors();
        cfg_write(2'd0, base);
        cfg_write(2'd1, AW'(cnt));
        per_en = 1'b1;
        cfg_write(2'd2, AW'({1'b1, burst, dir}));
        wait_irq();
        per_en = 1'b0;
        repeat (2) @(negedge clk);
        check(irq == 1'b1, "R11 irq after block", int'(irq), 1);
        check(bus_req == 1'b0, "R11 bus released", int'(bus_req), 0);
        check(ack_cnt == cnt, "R7/R8 ack count", ack_cnt, cnt);
        check(viol == 0, "R5 strobe without grant", viol, 0);
        for (int i = 0; i < cnt; i++) begin
            if (dir) check(rx[i] == pat(run, i), "R8 read data", int'(rx[i]), int'(pat(run, i)));
            else     check(mem[base + i] == pat(run, i), "R7 written data", int'(mem[base + i]), int'(pat(run, i)));
        end
        if (!dir) check(mem[base + cnt] == '0, "R7 no overrun", int'(mem[base + cnt]), 0);
        cfg_read(2'd0, rd);
        check(rd == base + AW'(cnt), "R6 final address", int'(rd), int'(base) + cnt);
        cfg_read(2'd1, rd);
        check(rd == '0, "R6 final count", int'(rd), 0);
        exp_rises = (cnt == 0) ? 0 : (burst ? 1 : cnt);
        check(req_rises == exp_rises, burst ? "R10 request rises" : "R9 request rises", req_rises, exp_rises);
        check(req_falls == req_rises, "R11 request released", req_falls, req_rises);
        exp_hold = (burst && gap && cnt > 0) ? 2 * (cnt - 1) : 0;
        check(hold_cycles == exp_hold, "R10 hold cycles", hold_cycles, exp_hold);
        repeat (4) @(negedge clk);
        check(irq == 1'b1, "R11 irq sticky", int'(irq), 1);
        cfg_write(2'd3, AW'(1));
        check(irq == 1'b0, "R11 irq cleared", int'(irq), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] rd;
        int run;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(bus_req == 1'b0, "R1 bus_req", int'(bus_req), 0);
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        for (int a = 0; a < 4; a++) begin
            cfg_read(2'(a), rd);
            check(rd == '0, "R1 register reset", int'(rd), 0);
        end

        // R2 register readback
        cfg_write(2'd0, 16'h1234);
        cfg_read(2'd0, rd);
        check(rd == 16'h1234, "R2 address readback", int'(rd), 16'h1234);
        cfg_write(2'd1, 16'h00A5);
        cfg_read(2'd1, rd);
        check(rd == 16'h00A5, "R2 count readback", int'(rd), 16'h00A5);
        cfg_write(2'd2, 16'h0003);
        cfg_read(2'd2, rd);
        check(rd == 16'h0003, "R2 control readback", int'(rd), 3);

        // R3 access blocked while granted
        force_gnt = 1'b1;
        repeat (2) @(negedge clk);
        cfg_write(2'd0, 16'h0055);
        cfg_read(2'd0, rd);
        check(rd == '0, "R3 read blocked", int'(rd), 0);
        force_gnt = 1'b0;
        repeat (2) @(negedge clk);
        cfg_read(2'd0, rd);
        check(rd == 16'h1234, "R3 write ignored", int'(rd), 16'h1234);

        // R12 zero count
        clear_monitors();
        cfg_write(2'd1, '0);
        per_en = 1'b1;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = 2'd2; cfg_wdata = 16'h0004;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b0;
        check(irq == 1'b1, "R12 irq next cycle", int'(irq), 1);
        repeat (4) @(negedge clk);
        check(req_rises == 0, "R12 no bus request", req_rises, 0);
        per_en = 1'b0;
        cfg_write(2'd3, AW'(1));

        // Sweep: direction x policy x count x pacing
        run = 0;
        for (int d = 0; d < 2; d++)
            for (int b = 0; b < 2; b++)
                for (int ci = 0; ci < 5; ci++)
                    for (int g = 0; g < 2; g++) begin
                        int cnts [5] = '{0, 1, 2, 3, 6};
                        run_block(d[0], b[0], cnts[ci], g[0], run);
                        run++;
                    end

        // R4 writes ignored while busy
        clear_monitors();
        cur_dir = 1'b0; cur_run = 41; gap_mode = 1'b0;
        for (int i = 0; i < 8; i++) mem[16 + 41 * 12 + i] = '0;
        cfg_write(2'd0, AW'(16 + 41 * 12));
        cfg_write(2'd1, AW'(4));
        cfg_write(2'd2, AW'(3'b100));
        cfg_write(2'd1, AW'(9));
        cfg_write(2'd2, AW'(3'b111));
        cfg_read(2'd1, rd);
        check(rd == AW'(4), "R4 count write ignored", int'(rd), 4);
        cfg_read(2'd2, rd);
        check(rd == '0, "R4 control write ignored", int'(rd), 0);
        cfg_read(2'd3, rd);
        check(rd == AW'(2), "R4 busy status", int'(rd), 2);
        per_en = 1'b1;
        wait_irq();
        per_en = 1'b0;
        repeat (2) @(negedge clk);
        check(ack_cnt == 4, "R4 original count kept", ack_cnt, 4);
        check(mem[16 + 41 * 12 + 3] == pat(41, 3), "R4 original direction kept",
              int'(mem[16 + 41 * 12 + 3]), int'(pat(41, 3)));
        check(req_rises == 4, "R4 original mode kept", req_rises, 4);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule